// File: doc/BRIEF.md
# GPIO Bank Controller with Edge/Level Interrupt Detection

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into banks of 32. A simple read/write port with byte addresses and 32-bit data reaches one 32-bit word per bank for each function.

Each function has a base offset, and bank `b` of that function sits at the base plus `4*b`. Pin `n` is bit `n % 32` of bank `n / 32`. Outputs are never written directly. Software pulses them high through a write-only set word and low through a write-only clear word, so concurrent users of one bank never need a read-modify-write. The direction word drives the output enables.

Every input passes through a synchronizer and then, unless bypassed, a stability filter. The conditioned value feeds a per-pin detector. That detector can flag rising edges, falling edges, both, or a steady active-high or active-low level. Detected events set sticky, write-one-to-clear status bits. The combined interrupt is the OR of status bits whose enable bit is set. A separate wake mask copies events into a second set of sticky status bits, which drive the wake output.

The default configuration has two banks (64 pins). Up to six banks fit before the function windows overlap.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register is 0. All pins are inputs (`pin_oe` = 0), `pin_out` = 0, and `irq` and `wake` are 0.
- R2: Function words sit at these base offsets plus 4 × bank: level 0x004, direction 0x01C, set 0x034, clear 0x04C, rising enable 0x064, falling enable 0x07C, filter bypass 0x094, interrupt enable 0x0AC, interrupt status 0x0C4, detect type 0x300, level polarity 0x318, wake mask 0x400, wake status 0x418. Pin n is bit n mod 32 of bank n/32.
- R3: The level word returns the pin inputs after a two-flop synchronizer. Writes to it have no effect.
- R4: Writing 1 to a bit of the set word drives that pin's output to 1, and writing 1 to a bit of the clear word drives it to 0. Zero bits leave outputs unchanged, and both words read as 0.
- R5: A direction bit of 1 makes the pin an output (`pin_oe` bit = 1). A direction bit of 0 makes it an input. The direction word reads back as written.
- R6: With detect type 0 (edge), a 0→1 transition of the conditioned input sets the status bit when rising enable is 1. A 1→0 transition sets it when falling enable is 1. Both may be enabled together, and with neither enabled nothing is flagged.
- R7: With detect type 1 (level), the status bit is set on every cycle the conditioned input is at its active level: high when the polarity bit is 0, low when it is 1.
- R8: Writing 1 to an interrupt status bit clears it unless an event arrives in the same cycle. Zero bits leave status unchanged.
- R9: `irq` is the OR over all banks of (status AND interrupt enable). A status bit whose enable is 0, or whose enable sits in another bank, does not raise `irq`.
- R10: With the bypass bit at 0, a new input value reaches the detector only after the synchronized input has held it for 3 consecutive clocks, so shorter pulses are dropped. With bypass at 1, the synchronized input goes straight to the detector.
- R11: An event on a pin whose wake mask bit is 1 sets its wake status bit, which is cleared by writing 1. `wake` is the OR of all wake status bits. With the mask at 0, no wake status is set.
- R12: Reads of unmapped or misaligned addresses return 0. Read data appears on `bus_rdata` the cycle after `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_BANKS*32 | Pin input levels |
| pin_out | output | NUM_BANKS*32 | Pin output values |
| pin_oe | output | NUM_BANKS*32 | Pin output enables |
| irq | output | 1 | Combined enabled interrupt |
| wake | output | 1 | Combined wake status |

## Verification
The detector is swept over all 32 combinations of detect type, polarity, rising enable, falling enable and filter bypass. Each combination runs on a different pin, spread across both banks. For each one the bench drives a rise and then a fall, clearing status between steps. This separates sticky edge capture from a level condition that re-arms after a clear, and it tells the two polarities apart. Short 1-, 2- and 4-cycle pulses separate filtered from bypassed inputs. Set/clear patterns with overlapping bits separate atomic updates from plain writes. Interrupt and wake tests place the status bit and its enable or mask in the same bank and in different banks, which shows whether the masking is per bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_PINS = 32;
    localparam int FN_COUNT  = 14;

    typedef enum logic [3:0] {
        FN_NONE  = 4'd0,
        FN_LEVEL = 4'd1,
        FN_DIR   = 4'd2,
        FN_SET   = 4'd3,
        FN_CLR   = 4'd4,
        FN_RISE  = 4'd5,
        FN_FALL  = 4'd6,
        FN_BYP   = 4'd7,
        FN_IEN   = 4'd8,
        FN_IST   = 4'd9,
        FN_ITYPE = 4'd10,
        FN_POL   = 4'd11,
        FN_WMASK = 4'd12,
        FN_WST   = 4'd13
    } gpio_fn_t;

    typedef struct packed {
        logic [BANK_PINS-1:0] dir;
        logic [BANK_PINS-1:0] outv;
        logic [BANK_PINS-1:0] rise;
        logic [BANK_PINS-1:0] fall;
        logic [BANK_PINS-1:0] byp;
        logic [BANK_PINS-1:0] ien;
        logic [BANK_PINS-1:0] ist;
        logic [BANK_PINS-1:0] itype;
        logic [BANK_PINS-1:0] pol;
        logic [BANK_PINS-1:0] wmask;
        logic [BANK_PINS-1:0] wst;
    } bank_regs_t;

    function automatic logic [11:0] fn_base(gpio_fn_t f);
        case (f)
            FN_LEVEL: return 12'h004;
            FN_DIR:   return 12'h01C;
            FN_SET:   return 12'h034;
            FN_CLR:   return 12'h04C;
            FN_RISE:  return 12'h064;
            FN_FALL:  return 12'h07C;
            FN_BYP:   return 12'h094;
            FN_IEN:   return 12'h0AC;
            FN_IST:   return 12'h0C4;
            FN_ITYPE: return 12'h300;
            FN_POL:   return 12'h318;
            FN_WMASK: return 12'h400;
            FN_WST:   return 12'h418;
            default:  return 12'h000;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_PINS-1:0] pin_i,
    input  logic [BANK_PINS-1:0] bypass_i,
    output logic [BANK_PINS-1:0] sync_o,
    output logic [BANK_PINS-1:0] cond_o
);

    localparam int CNT_W = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][BANK_PINS-1:0] sync;
        logic [BANK_PINS-1:0]                  cond;
        logic [BANK_PINS-1:0][CNT_W-1:0]       cnt;
    } cond_state_t;

    cond_state_t          st_d, st_q;
    logic [BANK_PINS-1:0] raw;

    assign raw = st_q.sync[SYNC_STAGES-1];

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pin_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        for (int i = 0; i < BANK_PINS; i++) begin
            if (bypass_i[i]) begin
                st_d.cond[i] = raw[i];
                st_d.cnt[i]  = '0;
            end else if (raw[i] == st_q.cond[i]) begin
                st_d.cnt[i]  = '0;
            end else if (st_q.cnt[i] == CNT_W'(FILT_CYCLES - 1)) begin
                st_d.cond[i] = raw[i];
                st_d.cnt[i]  = '0;
            end else begin
                st_d.cnt[i]  = st_q.cnt[i] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = raw;
    assign cond_o = st_q.cond;

    // A filtered pin may only change after its synchronized input held steady.
    generate
        if (FILT_CYCLES >= 2) begin : g_filt_chk
            assert_filter_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
                (((st_q.cond ^ $past(st_q.cond)) & ~$past(bypass_i)
                  & ($past(raw) ^ $past(raw, 2))) == '0));
        end
    endgenerate

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_PINS-1:0] cond_i,
    input  logic [BANK_PINS-1:0] rise_en_i,
    input  logic [BANK_PINS-1:0] fall_en_i,
    input  logic [BANK_PINS-1:0] level_i,
    input  logic [BANK_PINS-1:0] pol_i,
    output logic [BANK_PINS-1:0] evt_o
);

    typedef struct packed {
        logic [BANK_PINS-1:0] prev;
    } det_state_t;

    det_state_t           st_d, st_q;
    logic [BANK_PINS-1:0] edge_hit;
    logic [BANK_PINS-1:0] level_hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond_i;
        edge_hit  = (cond_i & ~st_q.prev & rise_en_i) | (~cond_i & st_q.prev & fall_en_i);
        level_hit = cond_i ^ pol_i;
        evt_o     = (level_i & level_hit) | (~level_i & edge_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  gpio_fn_t             fn_i,
    input  logic [31:0]          wdata_i,
    input  logic [BANK_PINS-1:0] pin_i,
    output logic [BANK_PINS-1:0] pin_o,
    output logic [BANK_PINS-1:0] oe_o,
    output logic [31:0]          rdata_o,
    output logic                 irq_o,
    output logic                 wake_o
);

    bank_regs_t           regs_d, regs_q;
    logic [BANK_PINS-1:0] sync_lvl, cond_lvl, evt;
    logic [BANK_PINS-1:0] set_m, clr_m, ist_clr, wst_clr;

    gpio_in_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .FILT_CYCLES (FILT_CYCLES)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .bypass_i (regs_q.byp),
        .sync_o   (sync_lvl),
        .cond_o   (cond_lvl)
    );

    gpio_evt_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond_lvl),
        .rise_en_i (regs_q.rise),
        .fall_en_i (regs_q.fall),
        .level_i   (regs_q.itype),
        .pol_i     (regs_q.pol),
        .evt_o     (evt)
    );

    always_comb begin
        regs_d  = regs_q;
        set_m   = (wr_en_i && fn_i == FN_SET) ? wdata_i : '0;
        clr_m   = (wr_en_i && fn_i == FN_CLR) ? wdata_i : '0;
        ist_clr = (wr_en_i && fn_i == FN_IST) ? wdata_i : '0;
        wst_clr = (wr_en_i && fn_i == FN_WST) ? wdata_i : '0;

        if (wr_en_i) begin
            case (fn_i)
                FN_DIR:   regs_d.dir   = wdata_i;
                FN_RISE:  regs_d.rise  = wdata_i;
                FN_FALL:  regs_d.fall  = wdata_i;
                FN_BYP:   regs_d.byp   = wdata_i;
                FN_IEN:   regs_d.ien   = wdata_i;
                FN_ITYPE: regs_d.itype = wdata_i;
                FN_POL:   regs_d.pol   = wdata_i;
                FN_WMASK: regs_d.wmask = wdata_i;
                default:  ;
            endcase
        end

        regs_d.outv = (regs_q.outv | set_m) & ~clr_m;
        regs_d.ist  = (regs_q.ist & ~ist_clr) | evt;
        regs_d.wst  = (regs_q.wst & ~wst_clr) | (evt & regs_q.wmask);

        case (fn_i)
            FN_LEVEL: rdata_o = sync_lvl;
            FN_DIR:   rdata_o = regs_q.dir;
            FN_RISE:  rdata_o = regs_q.rise;
            FN_FALL:  rdata_o = regs_q.fall;
            FN_BYP:   rdata_o = regs_q.byp;
            FN_IEN:   rdata_o = regs_q.ien;
            FN_IST:   rdata_o = regs_q.ist;
            FN_ITYPE: rdata_o = regs_q.itype;
            FN_POL:   rdata_o = regs_q.pol;
            FN_WMASK: rdata_o = regs_q.wmask;
            FN_WST:   rdata_o = regs_q.wst;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pin_o  = regs_q.outv;
    assign oe_o   = regs_q.dir;
    assign irq_o  = |(regs_q.ist & regs_q.ien);
    assign wake_o = |regs_q.wst;

    assert_set_drives_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_m) & ~$past(clr_m) & ~regs_q.outv) == '0));

    assert_clr_drives_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_m) & regs_q.outv) == '0));

    assert_evt_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt) & ~regs_q.ist) == '0));

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ist_clr) & ~$past(evt) & regs_q.ist) == '0));

    assert_wake_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt & regs_q.wmask) & ~regs_q.wst) == '0));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS   = 2,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_BANKS*BANK_PINS-1:0] pin_in,
    output logic [NUM_BANKS*BANK_PINS-1:0] pin_out,
    output logic [NUM_BANKS*BANK_PINS-1:0] pin_oe,
    output logic                           irq,
    output logic                           wake
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    typedef struct packed {
        logic [31:0] rdata;
    } top_state_t;

    top_state_t                  st_d, st_q;
    gpio_fn_t                    dec_fn;
    logic [BANK_W-1:0]           dec_bank;
    logic [31:0]                 addr_ext;
    logic [NUM_BANKS-1:0][31:0]  bank_rd;
    logic [NUM_BANKS-1:0]        irq_v, wake_v;

    assign addr_ext = 32'(bus_addr);

    always_comb begin
        dec_fn   = FN_NONE;
        dec_bank = '0;
        for (int f = 1; f < FN_COUNT; f++) begin
            if (addr_ext[1:0] == 2'b00
                && addr_ext >= 32'(fn_base(gpio_fn_t'(f)))
                && addr_ext <  32'(fn_base(gpio_fn_t'(f))) + 32'(4 * NUM_BANKS)) begin
                dec_fn   = gpio_fn_t'(f);
                dec_bank = BANK_W'((addr_ext - 32'(fn_base(gpio_fn_t'(f)))) >> 2);
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            gpio_bank #(
                .SYNC_STAGES (SYNC_STAGES),
                .FILT_CYCLES (FILT_CYCLES)
            ) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en_i (bus_wr && dec_fn != FN_NONE && dec_bank == BANK_W'(g)),
                .fn_i    (dec_bank == BANK_W'(g) ? dec_fn : FN_NONE),
                .wdata_i (bus_wdata),
                .pin_i   (pin_in[g*BANK_PINS +: BANK_PINS]),
                .pin_o   (pin_out[g*BANK_PINS +: BANK_PINS]),
                .oe_o    (pin_oe[g*BANK_PINS +: BANK_PINS]),
                .rdata_o (bank_rd[g]),
                .irq_o   (irq_v[g]),
                .wake_o  (wake_v[g])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (bus_rd) begin
            st_d.rdata = (dec_fn == FN_NONE) ? 32'h0 : bank_rd[dec_bank];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign irq       = |irq_v;
    assign wake      = |wake_v;

    assert_unmapped_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && $past(dec_fn) == FN_NONE) |-> (bus_rdata == 32'h0));

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_bank_ctrl;

    localparam int NB = 2;
    localparam int NP = NB * 32;

    localparam logic [11:0] A_LVL = 12'h004, A_DIR = 12'h01C, A_SET = 12'h034, A_CLR = 12'h04C;
    localparam logic [11:0] A_RIS = 12'h064, A_FAL = 12'h07C, A_BYP = 12'h094, A_IEN = 12'h0AC;
    localparam logic [11:0] A_IST = 12'h0C4, A_TYP = 12'h300, A_POL = 12'h318, A_WMK = 12'h400;
    localparam logic [11:0] A_WST = 12'h418;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq, wake;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ba(input logic [11:0] base, input int bank);
        return base + 12'(4 * bank);
    endfunction

    task automatic pulse(input int pin, input int n);
        @(negedge clk);
        pin_in[pin] = 1'b1;
        tick(n);
        pin_in[pin] = 1'b0;
    endtask

    task automatic clear_cfg();
        for (int b = 0; b < NB; b++) begin
            wr(ba(A_RIS, b), 0); wr(ba(A_FAL, b), 0); wr(ba(A_TYP, b), 0);
            wr(ba(A_POL, b), 0); wr(ba(A_BYP, b), 0); wr(ba(A_IEN, b), 0);
            wr(ba(A_WMK, b), 0);
        end
        tick(12);
        for (int b = 0; b < NB; b++) begin
            wr(ba(A_IST, b), 32'hFFFF_FFFF); wr(ba(A_WST, b), 32'hFFFF_FFFF);
        end
    endtask

    // R6/R7 sweep: one configuration per call, on its own pin.
    task automatic run_cfg(input int c);
        logic        ty = c[0], po = c[1], ri = c[2], fa = c[3], by = c[4];
        int          pin = (c * 5) % NP;
        int          bk = pin / 32;
        logic [31:0] m = 32'd1 << (pin % 32);
        logic [31:0] d;
        string       tg = ty ? "R7 level" : "R6 edge";
        clear_cfg();
        wr(ba(A_RIS, bk), ri ? m : 0);
        wr(ba(A_FAL, bk), fa ? m : 0);
        wr(ba(A_POL, bk), po ? m : 0);
        wr(ba(A_TYP, bk), ty ? m : 0);
        wr(ba(A_BYP, bk), by ? m : 0);
        tick(12);
        wr(ba(A_IST, bk), 32'hFFFF_FFFF); tick(3);
        rd(ba(A_IST, bk), d); chk(tg, d, (ty & po) ? m : 0);
        @(negedge clk); pin_in[pin] = 1'b1; tick(12);
        rd(ba(A_IST, bk), d); chk(tg, d, (ty | ri) ? m : 0);
        wr(ba(A_IST, bk), 32'hFFFF_FFFF); tick(3);
        rd(ba(A_IST, bk), d); chk(tg, d, (ty & ~po) ? m : 0);
        @(negedge clk); pin_in[pin] = 1'b0; tick(12);
        rd(ba(A_IST, bk), d); chk(tg, d, (ty | fa) ? m : 0);
        wr(ba(A_IST, bk), 32'hFFFF_FFFF); tick(3);
        rd(ba(A_IST, bk), d); chk(tg, d, (ty & po) ? m : 0);
    endtask

    initial begin
        logic [31:0] d;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 irq/wake", {irq, wake}, 0);
        rd(ba(A_DIR, 1), d); chk("R1 dir", d, 0);
        rd(ba(A_IST, 0), d); chk("R1 status", d, 0);

        // R3 level readback, R2 bank mapping
        @(negedge clk); pin_in = 64'h1234_5678_9ABC_DEF0; tick(4);
        rd(ba(A_LVL, 0), d); chk("R3 level bank0", d, 32'h9ABC_DEF0);
        rd(ba(A_LVL, 1), d); chk("R2/R3 level bank1", d, 32'h1234_5678);
        wr(ba(A_LVL, 0), 32'hFFFF_FFFF);
        rd(ba(A_LVL, 0), d); chk("R3 level write ignored", d, 32'h9ABC_DEF0);
        @(negedge clk); pin_in = '0;
        clear_cfg();

        // R4 set / clear
        wr(ba(A_SET, 0), 32'h0000_00F0); tick(1); chk("R4 set", pin_out, 64'hF0);
        wr(ba(A_SET, 0), 32'h0000_000F); tick(1); chk("R4 set keeps others", pin_out, 64'hFF);
        wr(ba(A_CLR, 0), 32'h0000_003C); tick(1); chk("R4 clear", pin_out, 64'hC3);
        wr(ba(A_SET, 1), 32'h0000_0001); tick(1); chk("R2/R4 set bank1", pin_out, 64'h1_0000_00C3);
        wr(ba(A_SET, 0), 32'h0); wr(ba(A_CLR, 0), 32'h0); tick(1);
        chk("R4 zero writes", pin_out, 64'h1_0000_00C3);
        rd(ba(A_SET, 0), d); chk("R4 set reads zero", d, 0);
        rd(ba(A_CLR, 1), d); chk("R4 clear reads zero", d, 0);

        // R5 direction
        wr(ba(A_DIR, 1), 32'h8000_0001); tick(1);
        chk("R5 pin_oe", pin_oe, 64'h8000_0001_0000_0000);
        rd(ba(A_DIR, 1), d); chk("R5 dir readback", d, 32'h8000_0001);

        // R12 unmapped reads
        rd(12'h000, d); chk("R12 addr 0x000", d, 0);
        rd(ba(A_IST, 2), d); chk("R12 beyond banks", d, 0);
        rd(12'h01D, d); chk("R12 misaligned", d, 0);

        // R6/R7 sweep
        for (int c = 0; c < 32; c++) run_cfg(c);
        clear_cfg();

        // R10 filter
        wr(ba(A_RIS, 0), 32'h8);
        tick(6);
        pulse(3, 2); tick(12);
        rd(ba(A_IST, 0), d); chk("R10 short pulse dropped", d, 0);
        pulse(3, 4); tick(12);
        rd(ba(A_IST, 0), d); chk("R10 long pulse passes", d, 32'h8);
        wr(ba(A_IST, 0), 32'h8);
        wr(ba(A_BYP, 0), 32'h8); tick(2);
        pulse(3, 1); tick(12);
        rd(ba(A_IST, 0), d); chk("R10 bypass passes 1-cycle", d, 32'h8);

        // R9 interrupt masking, R8 W1C
        tick(1); chk("R9 disabled status", irq, 0);
        wr(ba(A_IEN, 1), 32'h8); tick(1); chk("R9 enable in other bank", irq, 0);
        wr(ba(A_IEN, 0), 32'h8); tick(1); chk("R9 enabled status", irq, 1);
        wr(ba(A_IST, 0), 32'h1);
        rd(ba(A_IST, 0), d); chk("R8 zero bits keep status", d, 32'h8);
        wr(ba(A_IST, 0), 32'h8); tick(1);
        chk("R8/R9 irq after clear", irq, 0);
        rd(ba(A_IST, 0), d); chk("R8 status cleared", d, 0);

        // R11 wake
        clear_cfg();
        wr(ba(A_RIS, 1), 32'h100); wr(ba(A_BYP, 1), 32'h100); wr(ba(A_WMK, 1), 32'h100);
        tick(4);
        pulse(40, 1); tick(12);
        chk("R11 wake set", wake, 1);
        rd(ba(A_WST, 1), d); chk("R11 wake status", d, 32'h100);
        wr(ba(A_WST, 1), 32'h100); tick(1);
        chk("R11 wake cleared", wake, 0);
        wr(ba(A_WMK, 1), 32'h0); tick(2);
        pulse(40, 1); tick(12);
        chk("R11 unmasked no wake", wake, 0);
        rd(ba(A_IST, 1), d); chk("R11 event still in status", d, 32'h100);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule